// File: doc/BRIEF.md
# Display Mode Control Register

This block is a single control register on an 8-bit I/O bus with 16 address lines. It answers to any port address whose low byte is all ones and ignores the upper address byte. A write latches four things: a 3-bit display mode, a 3-bit hi-res ink colour, an interrupt-block flag and a spare paging bit. The spare bit is kept but drives nothing.

From the stored value, the block drives four one-hot status lines: normal screen, alternate screen, hi-colour and hi-res. It also produces the hi-res colours:

- the ink colour, as stored;
- the paper colour, which is the bitwise complement of the ink;
- the composed attribute byte `01pppiii`, where `ppp` is the paper and `iii` is the ink.

In hi-res mode, the border colour coming from the separate border port is replaced by the paper colour.

The interrupt request to the CPU passes through a gate that the stored flag can close. The CPU's own enable-interrupt instruction cannot reopen it. Reads of the port return the stored byte only while an external readback-enable input is high. In every other case the read data is the floating-bus value.

Top module: `vmc_port`

## Requirements
- R1: After reset the stored byte is 0x00. The normal-screen status is high, the ink is 0 and the interrupt request passes through.
- R2: A write happens on a rising clock edge where io_req_i and io_wr_i are both 1 and addr_i[7:0] equals 0xFF. Any value of addr_i[15:8] is accepted. The new value appears on the outputs after that edge.
- R3: The stored byte does not change in any of these cases: the low address byte differs from 0xFF, io_req_i is 0, or io_wr_i is 0.
- R4: Bits 2:0 select the mode: 000 gives normal, 001 gives alternate screen, 010 gives hi-colour and 110 gives hi-res. Exactly one status line is high at any time.
- R5: The mode codes 011, 100, 101 and 111 are treated as normal screen.
- R6: Bits 5:3 are the ink colour. The paper is the bitwise complement of the ink. attr_o equals {2'b01, paper, ink}.
- R7: While bit 6 is 1, irq_o is 0 whatever irq_i is. While bit 6 is 0, irq_o follows irq_i.
- R8: Bit 7 is stored and is returned on readback. It changes none of the other outputs.
- R9: With rb_en_i = 1, a read (io_req_i = 1, io_rd_i = 1, addr_i[7:0] = 0xFF) returns the stored byte in the same cycle.
- R10: With rb_en_i = 0, or when no read of this port is in progress, rd_data_o equals float_i.
- R11: In hi-res mode, border_o equals the paper colour. In every other mode, border_o equals border_i.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| addr_i | input | 16 | I/O address |
| io_req_i | input | 1 | I/O request strobe, active high |
| io_wr_i | input | 1 | Write strobe, active high |
| io_rd_i | input | 1 | Read strobe, active high |
| wr_data_i | input | 8 | Write data |
| rb_en_i | input | 1 | Readback enable from elsewhere |
| float_i | input | 8 | Floating-bus data |
| rd_data_o | output | 8 | Read data |
| irq_i | input | 1 | Interrupt request from the source |
| irq_o | output | 1 | Gated interrupt request to the CPU |
| border_i | input | 3 | Border colour from the border port |
| border_o | output | 3 | Border colour in effect |
| mode_std_o | output | 1 | Normal screen selected |
| mode_alt_o | output | 1 | Alternate screen selected |
| mode_hicol_o | output | 1 | Hi-colour selected |
| mode_hires_o | output | 1 | Hi-res selected |
| ink_o | output | 3 | Hi-res ink colour |
| paper_o | output | 3 | Hi-res paper colour |
| attr_o | output | 8 | Composed hi-res attribute byte |

## Verification
The bench builds the block with its default parameters: a 16-bit address, an 8-bit select field and the match value 0xFF. With these values the address lines above the select field are real inputs. This lets the bench vary the upper byte and show that it is ignored, and also send near-miss low bytes that must not write. All eight mode codes can be written, which covers both the listed modes and the ones that fall back to normal screen.

// File: rtl/vmc_pkg.sv
package vmc_pkg;
    localparam int MODE_W = 3;
    localparam int CLR_W  = 3;

    localparam logic [MODE_W-1:0] CODE_ALT   = 3'b001;
    localparam logic [MODE_W-1:0] CODE_HICOL = 3'b010;
    localparam logic [MODE_W-1:0] CODE_HIRES = 3'b110;

    typedef enum logic [1:0] {
        VM_STD   = 2'd0,
        VM_ALT   = 2'd1,
        VM_HICOL = 2'd2,
        VM_HIRES = 2'd3
    } vmode_e;

    localparam int NUM_MODES = 4;

    // stored byte, MSB first: spare, irq block, ink, mode
    typedef struct packed {
        logic              spare;
        logic              irq_block;
        logic [CLR_W-1:0]  ink;
        logic [MODE_W-1:0] mode;
    } ctrl_t;

    localparam int CTRL_W = $bits(ctrl_t);
endpackage

// File: rtl/vmc_sel.sv
module vmc_sel #(
    parameter int               SEL_W   = 8,
    parameter logic [SEL_W-1:0] SEL_VAL = '1
) (
    input  logic [SEL_W-1:0] sel_addr_i,
    input  logic             req_i,
    input  logic             wr_i,
    input  logic             rd_i,
    output logic             wr_hit_o,
    output logic             rd_hit_o
);
    logic match;

    always_comb begin
        match    = (sel_addr_i == SEL_VAL);
        wr_hit_o = match && req_i && wr_i;
        rd_hit_o = match && req_i && rd_i;
    end
endmodule

// File: rtl/vmc_mode_dec.sv
module vmc_mode_dec
    import vmc_pkg::*;
(
    input  logic [MODE_W-1:0]   mode_i,
    input  logic [CLR_W-1:0]    ink_i,
    input  logic [CLR_W-1:0]    border_i,
    output logic [NUM_MODES-1:0] flags_o,
    output logic [CLR_W-1:0]    paper_o,
    output logic [CTRL_W-1:0]   attr_o,
    output logic [CLR_W-1:0]    border_o
);
    vmode_e vm;

    always_comb begin
        unique case (mode_i)
            CODE_ALT:   vm = VM_ALT;
            CODE_HICOL: vm = VM_HICOL;
            CODE_HIRES: vm = VM_HIRES;
            default:    vm = VM_STD;
        endcase
    end

    for (genvar g = 0; g < NUM_MODES; g++) begin : g_flag
        assign flags_o[g] = (vm == vmode_e'(g));
    end

    always_comb begin
        paper_o  = ~ink_i;
        attr_o   = {2'b01, paper_o, ink_i};
        border_o = (vm == VM_HIRES) ? paper_o : border_i;
    end
endmodule

// File: rtl/vmc_rdmux.sv
module vmc_rdmux #(
    parameter int DATA_W = 8
) (
    input  logic              rd_hit_i,
    input  logic              rb_en_i,
    input  logic [DATA_W-1:0] reg_i,
    input  logic [DATA_W-1:0] float_i,
    output logic [DATA_W-1:0] data_o
);
    always_comb begin
        data_o = (rd_hit_i && rb_en_i) ? reg_i : float_i;
    end
endmodule

// File: rtl/vmc_port.sv
module vmc_port
    import vmc_pkg::*;
#(
    parameter int               ADDR_W  = 16,
    parameter int               SEL_W   = 8,
    parameter logic [SEL_W-1:0] SEL_VAL = '1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic              io_req_i,
    input  logic              io_wr_i,
    input  logic              io_rd_i,
    input  logic [CTRL_W-1:0] wr_data_i,
    input  logic              rb_en_i,
    input  logic [CTRL_W-1:0] float_i,
    output logic [CTRL_W-1:0] rd_data_o,
    input  logic              irq_i,
    output logic              irq_o,
    input  logic [CLR_W-1:0]  border_i,
    output logic [CLR_W-1:0]  border_o,
    output logic              mode_std_o,
    output logic              mode_alt_o,
    output logic              mode_hicol_o,
    output logic              mode_hires_o,
    output logic [CLR_W-1:0]  ink_o,
    output logic [CLR_W-1:0]  paper_o,
    output logic [CTRL_W-1:0] attr_o
);
    localparam int HI_W = ADDR_W - SEL_W;

    ctrl_t st_d, st_q;
    logic  wr_hit, rd_hit;
    logic [NUM_MODES-1:0] flags;
    logic  unused_hi;

    assign unused_hi = ^addr_i[ADDR_W-1:ADDR_W-HI_W];

    vmc_sel #(.SEL_W(SEL_W), .SEL_VAL(SEL_VAL)) u_sel (
        .sel_addr_i (addr_i[SEL_W-1:0]),
        .req_i      (io_req_i),
        .wr_i       (io_wr_i),
        .rd_i       (io_rd_i),
        .wr_hit_o   (wr_hit),
        .rd_hit_o   (rd_hit)
    );

    always_comb begin
        st_d = st_q;
        if (wr_hit) begin
            st_d = ctrl_t'(wr_data_i);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    vmc_mode_dec u_dec (
        .mode_i   (st_q.mode),
        .ink_i    (st_q.ink),
        .border_i (border_i),
        .flags_o  (flags),
        .paper_o  (paper_o),
        .attr_o   (attr_o),
        .border_o (border_o)
    );

    assign mode_std_o   = flags[VM_STD];
    assign mode_alt_o   = flags[VM_ALT];
    assign mode_hicol_o = flags[VM_HICOL];
    assign mode_hires_o = flags[VM_HIRES];
    assign ink_o        = st_q.ink;
    assign irq_o        = irq_i & ~st_q.irq_block;

    vmc_rdmux #(.DATA_W(CTRL_W)) u_rd (
        .rd_hit_i (rd_hit),
        .rb_en_i  (rb_en_i),
        .reg_i    (st_q),
        .float_i  (float_i),
        .data_o   (rd_data_o)
    );

    AST_WR_LATCH: assert property (@(posedge clk) disable iff (!rst_n)
        wr_hit |=> (st_q == $past(wr_data_i)));  // R2
    AST_HOLD_NO_HIT: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_hit |=> $stable(st_q));  // R3
    AST_ONE_MODE: assert property (@(posedge clk) disable iff (!rst_n)
        $countones({mode_std_o, mode_alt_o, mode_hicol_o, mode_hires_o}) == 1);  // R4
    AST_IRQ_BLOCK: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.irq_block |-> !irq_o);  // R7
    AST_BORDER_HIRES: assert property (@(posedge clk) disable iff (!rst_n)
        mode_hires_o |-> (border_o == ~ink_o));  // R11
    AST_FLOAT_NO_RB: assert property (@(posedge clk) disable iff (!rst_n)
        !rb_en_i |-> (rd_data_o == float_i));  // R10
endmodule

// File: tb/vmc_port_bench.sv
module vmc_port_bench;
    logic        clk = 0;
    logic        rst_n = 0;
    logic [15:0] addr = 0;
    logic        req = 0, wr = 0, rd = 0, rb_en = 0, irq_in = 0;
    logic [7:0]  wdata = 0, flt = 8'h5A;
    logic [2:0]  bin = 3'd2;
    logic [7:0]  rdata, attr;
    logic        irq_out, m_std, m_alt, m_hc, m_hr;
    logic [2:0]  bout, ink, paper;
    int checks = 0, fails = 0;
    logic [7:0]  shadow = 0;

    always #5 clk = ~clk;

    vmc_port u_vmc_port (
        .clk(clk), .rst_n(rst_n), .addr_i(addr), .io_req_i(req), .io_wr_i(wr),
        .io_rd_i(rd), .wr_data_i(wdata), .rb_en_i(rb_en), .float_i(flt),
        .rd_data_o(rdata), .irq_i(irq_in), .irq_o(irq_out), .border_i(bin),
        .border_o(bout), .mode_std_o(m_std), .mode_alt_o(m_alt),
        .mode_hicol_o(m_hc), .mode_hires_o(m_hr), .ink_o(ink), .paper_o(paper),
        .attr_o(attr)
    );

    task automatic chk(input string req_s, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req_s, act, exp);
        end
    endtask

    function automatic logic [3:0] exp_flags(input logic [2:0] m);
        case (m)
            3'b001:  return 4'b0010;
            3'b010:  return 4'b0100;
            3'b110:  return 4'b1000;
            default: return 4'b0001;
        endcase
    endfunction

    task automatic io_write(input logic [15:0] a, input logic [7:0] d,
                            input logic rq, input logic w);
        @(negedge clk);
        addr = a; wdata = d; req = rq; wr = w;
        @(negedge clk);
        req = 0; wr = 0;
        if (rq && w && a[7:0] == 8'hFF) shadow = d;
    endtask

    task automatic io_read(input logic [15:0] a, output logic [7:0] d);
        @(negedge clk);
        addr = a; req = 1; rd = 1;
        #1 d = rdata;
        req = 0; rd = 0;
    endtask

    task automatic t_reset;
        chk("R1 byte", rdata == flt ? 8'h00 : 8'hEE, 8'h00);
        chk("R1 flags", {4'b0, m_hr, m_hc, m_alt, m_std}, 8'h01);
        chk("R1 ink", {5'b0, ink}, 8'h00);
        irq_in = 1; #1;
        chk("R1 irq", {7'b0, irq_out}, 8'h01);
        irq_in = 0;
    endtask

    task automatic t_modes;
        for (int m = 0; m < 8; m++) begin
            io_write(16'h12FF, {5'b0, m[2:0]}, 1, 1);
            chk((m == 3 || m == 4 || m == 5 || m == 7) ? "R5 fallback" : "R4 mode",
                {4'b0, m_hr, m_hc, m_alt, m_std}, {4'b0, exp_flags(m[2:0])});
        end
    endtask

    task automatic t_upper_ignored;
        io_write(16'hA5FF, 8'h02, 1, 1);
        chk("R2 upper byte", {4'b0, m_hr, m_hc, m_alt, m_std}, 8'h04);
    endtask

    task automatic t_no_write;
        io_write(16'h00FE, 8'h06, 1, 1);
        chk("R3 addr FE", {4'b0, m_hr, m_hc, m_alt, m_std}, 8'h04);
        io_write(16'h00FF, 8'h06, 0, 1);
        chk("R3 no req", {4'b0, m_hr, m_hc, m_alt, m_std}, 8'h04);
        io_write(16'h00FF, 8'h06, 1, 0);
        chk("R3 no wr", {4'b0, m_hr, m_hc, m_alt, m_std}, 8'h04);
        io_write(16'hFF7F, 8'h06, 1, 1);
        chk("R3 addr 7F", {4'b0, m_hr, m_hc, m_alt, m_std}, 8'h04);
    endtask

    task automatic t_colours;
        io_write(16'h00FF, 8'b0010_0110, 1, 1);
        chk("R6 ink", {5'b0, ink}, 8'h04);
        chk("R6 paper", {5'b0, paper}, 8'h03);
        chk("R6 attr", attr, 8'b0101_1100);
        chk("R11 border hires", {5'b0, bout}, 8'h03);
        io_write(16'h00FF, 8'b0010_0010, 1, 1);
        chk("R11 border hicol", {5'b0, bout}, {5'b0, bin});
    endtask

    task automatic t_irq;
        io_write(16'h00FF, 8'h40, 1, 1);
        irq_in = 1; #1;
        chk("R7 blocked", {7'b0, irq_out}, 8'h00);
        io_write(16'h00FF, 8'h00, 1, 1);
        #1;
        chk("R7 passes", {7'b0, irq_out}, 8'h01);
        irq_in = 0;
    endtask

    task automatic t_readback;
        logic [7:0] d;
        io_write(16'h00FF, 8'h80, 1, 1);
        chk("R8 flags", {4'b0, m_hr, m_hc, m_alt, m_std}, 8'h01);
        chk("R8 attr", attr, 8'b0111_1000);
        rb_en = 1;
        io_read(16'h33FF, d);
        chk("R8 R9 readback", d, 8'h80);
        io_write(16'h00FF, 8'hE9, 1, 1);
        io_read(16'h00FF, d);
        chk("R9 readback", d, shadow);
        io_read(16'h00FE, d);
        chk("R10 other port", d, flt);
        rb_en = 0;
        io_read(16'h00FF, d);
        chk("R10 rb off", d, flt);
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        fails++; checks++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1;
        @(negedge clk);
        t_reset();
        t_modes();
        t_upper_ignored();
        t_no_write();
        t_colours();
        t_irq();
        t_readback();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule